// File: doc/BRIEF.md
# Cascaded Two-Stage Escalation Watchdog

This block links two watchdog stages so that a fault seen on a suspension escalates first to the isolation platform in the same chamber, and later to the suspension itself. The upstream stage watches a level-exceeded flag produced by an RMS comparator outside the block. The downstream stage watches the upstream stage's health link. Each stage runs a first countdown and then a second countdown, and each countdown is a number of timebase ticks. When its second countdown ends, a stage cuts its own group of DAC outputs.

The downstream stage raises a shutdown warning when it starts its second countdown. This gives client logic one short interval to park cleanly before the isolation DACs are cut. With the default counts, one tick stands for one minute. Isolation DACs are cut at tick 10 and suspension DACs at tick 20 after the trip. A hardware-mode select doubles every interval. In that mode a separate timer removes coil-driver power after the level flag has stayed high without a break for a set number of ticks.

All link, warning, kill and power outputs latch. They are released only by a clear request made while the level flag is low.

Top module: `cascade_wdog`

## Requirements
- R1: After reset, every output is low and both stage states read IDLE.
- R2: When `over_level` rises, the upstream stage enters COUNT1 at once. Time passes only on cycles with `tick` high. After SUS_T1 ticks (default 5), `sus_link_bad` goes high and the stage enters COUNT2.
- R3: If `over_level` falls while the upstream stage is in COUNT1, the stage returns to IDLE and discards its count. A later trip needs the full SUS_T1 ticks again.
- R4: The downstream stage enters COUNT1 on the cycle after `sus_link_bad` rises. After SEI_T1 further ticks (trip tick 9 by default), `sei_link_bad` and `warn_shutdown` go high and the stage enters COUNT2.
- R5: After SEI_T2 more ticks, `sei_dac_kill` asserts. This is trip tick 10 by default, and always before `sus_dac_kill`.
- R6: SUS_T2 ticks after `sus_link_bad` rises (trip tick 20 by default), `sus_dac_kill` asserts.
- R7: With `hw_mode` high, every countdown is twice as long. By default, `sus_link_bad` rises at trip tick 10, `sei_dac_kill` at 20 and `sus_dac_kill` at 40.
- R8: `coil_pwr_off` asserts only with `hw_mode` high, after PWR_T ticks (default 20) of `over_level` held high without a break. A drop of `over_level` restarts this count.
- R9: Link, warning, kill and power outputs stay high after `over_level` falls. A `clear_req` made while `over_level` is high is ignored.
- R10: A `clear_req` made while `over_level` is low returns both stages to IDLE and drops every output on the next clock edge.
- R11: Each state output is one-hot: IDLE=4'b0001, COUNT1=4'b0010, COUNT2=4'b0100, KILLED=4'b1000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle timebase strobe |
| over_level | input | 1 | RMS trip level exceeded |
| clear_req | input | 1 | Clear request, honoured only while over_level is low |
| hw_mode | input | 1 | Hardware mode: doubles all intervals, enables power removal |
| sus_link_bad | output | 1 | Upstream health link BAD |
| sei_link_bad | output | 1 | Downstream health link BAD |
| warn_shutdown | output | 1 | Shutdown warning to isolation client logic |
| sei_dac_kill | output | 1 | Isolation DAC group disabled |
| sus_dac_kill | output | 1 | Suspension DAC group disabled |
| coil_pwr_off | output | 1 | Coil-driver power removal |
| sus_state | output | 4 | Upstream stage state, one-hot |
| sei_state | output | 4 | Downstream stage state, one-hot |

## Verification
The bench holds the trip flag high with no tick strobes, to show that the timebase alone moves the countdowns. It then runs an unbroken trip and checks each output on the tick before its edge and on the tick of its edge. This separates an off-by-one count from a wrong interval.

A trip that is dropped inside the first countdown and then raised again shows whether the count is discarded or kept. The same chain in hardware mode tells a doubled interval from a normal one. A broken trip in hardware mode shows whether the power timer needs an unbroken run or only a total count. Clear requests made with the flag high and with it low test the release rule.

// File: rtl/cascade_wdog_pkg.sv
package cascade_wdog_pkg;

   // One-hot stage state; bit positions are visible at the ports
   typedef enum logic [3:0] {
      ST_IDLE = 4'b0001,
      ST_RUN1 = 4'b0010,
      ST_RUN2 = 4'b0100,
      ST_DEAD = 4'b1000
   } wd_state_e;

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/wdog_stage.sv
module wdog_stage
   import cascade_wdog_pkg::*;
#(
   parameter int T1       = 5,
   parameter int T2       = 15,
   parameter bit ABORT_EN = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       start,
   input  logic       clr,
   input  logic       hw_mode,
   output logic [3:0] state_o,
   output logic       link_bad_o,
   output logic       kill_o
);

   localparam int TMAX = max2(T1, T2);
   localparam int LW   = $clog2(2 * TMAX + 1);

   if (T1 < 1 || T2 < 1) begin : g_bad_len
      $error("wdog_stage: both intervals must be at least one tick");
   end

   wd_state_e      st_q;
   logic [LW-1:0]  cnt_q;
   logic [LW-1:0]  lim;

   always_comb begin
      lim = (st_q == ST_RUN1) ? LW'(T1) : LW'(T2);
      if (hw_mode) lim = lim << 1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         st_q  <= ST_IDLE;
         cnt_q <= '0;
      end else begin
         unique case (st_q)
            ST_IDLE: begin
               if (start) begin
                  st_q  <= ST_RUN1;
                  cnt_q <= '0;
               end
            end
            ST_RUN1: begin
               if (ABORT_EN && !start) begin
                  st_q  <= ST_IDLE;
                  cnt_q <= '0;
               end else if (tick) begin
                  if (cnt_q == lim - 1'b1) begin
                     st_q  <= ST_RUN2;
                     cnt_q <= '0;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
            end
            ST_RUN2: begin
               if (tick) begin
                  if (cnt_q == lim - 1'b1) begin
                     st_q  <= ST_DEAD;
                     cnt_q <= '0;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
            end
            default: begin
               st_q <= ST_DEAD;
            end
         endcase
      end
   end

   assign state_o    = st_q;
   assign link_bad_o = (st_q == ST_RUN2) || (st_q == ST_DEAD);
   assign kill_o     = (st_q == ST_DEAD);

   assert_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(state_o) == 1);

   assert_cnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_RUN1 || st_q == ST_RUN2) |-> (cnt_q < lim));

   assert_kill_from_run2_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(kill_o) |-> $past(st_q) == ST_RUN2);

   assert_kill_latched_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (kill_o && !clr) |=> kill_o);

   if (ABORT_EN) begin : g_abort_chk
      assert_abort_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (st_q == ST_RUN1 && !start) |=> (st_q == ST_IDLE));
   end

endmodule

// File: rtl/wdog_hold_timer.sv
module wdog_hold_timer #(
   parameter int LIMIT = 20
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic active,
   input  logic clr,
   output logic fired_o
);

   localparam int CW = $clog2(LIMIT + 1);

   if (LIMIT < 1) begin : g_bad_limit
      $error("wdog_hold_timer: LIMIT must be at least one tick");
   end

   logic [CW-1:0] cnt_q;
   logic          fired_q;

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         cnt_q   <= '0;
         fired_q <= 1'b0;
      end else if (!active) begin
         cnt_q <= '0;
      end else if (tick && !fired_q) begin
         if (cnt_q == CW'(LIMIT - 1)) fired_q <= 1'b1;
         else                         cnt_q   <= cnt_q + 1'b1;
      end
   end

   assign fired_o = fired_q;

   assert_fire_latched_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (fired_q && !clr) |=> fired_q);

endmodule

// File: rtl/cascade_wdog.sv
module cascade_wdog
   import cascade_wdog_pkg::*;
#(
   parameter int SUS_T1 = 5,
   parameter int SUS_T2 = 15,
   parameter int SEI_T1 = 4,
   parameter int SEI_T2 = 1,
   parameter int PWR_T  = 20,
   parameter bit PWR_EN = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       over_level,
   input  logic       clear_req,
   input  logic       hw_mode,
   output logic       sus_link_bad,
   output logic       sei_link_bad,
   output logic       warn_shutdown,
   output logic       sei_dac_kill,
   output logic       sus_dac_kill,
   output logic       coil_pwr_off,
   output logic [3:0] sus_state,
   output logic [3:0] sei_state
);

   if (SUS_T2 <= SEI_T1 + SEI_T2) begin : g_bad_order
      $error("cascade_wdog: isolation kill must precede suspension kill");
   end

   logic clr_ok;
   assign clr_ok = clear_req & ~over_level;

   wdog_stage #(.T1(SUS_T1), .T2(SUS_T2), .ABORT_EN(1'b1)) u_sus (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick),
      .start      (over_level),
      .clr        (clr_ok),
      .hw_mode    (hw_mode),
      .state_o    (sus_state),
      .link_bad_o (sus_link_bad),
      .kill_o     (sus_dac_kill)
   );

   wdog_stage #(.T1(SEI_T1), .T2(SEI_T2), .ABORT_EN(1'b0)) u_sei (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick),
      .start      (sus_link_bad),
      .clr        (clr_ok),
      .hw_mode    (hw_mode),
      .state_o    (sei_state),
      .link_bad_o (sei_link_bad),
      .kill_o     (sei_dac_kill)
   );

   assign warn_shutdown = sei_link_bad;

   if (PWR_EN) begin : g_pwr
      wdog_hold_timer #(.LIMIT(PWR_T)) u_pwr (
         .clk     (clk),
         .rst_n   (rst_n),
         .tick    (tick),
         .active  (over_level & hw_mode),
         .clr     (clr_ok),
         .fired_o (coil_pwr_off)
      );
   end else begin : g_no_pwr
      assign coil_pwr_off = 1'b0;
   end

   assert_iso_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
      sus_dac_kill |-> sei_dac_kill);

   assert_warn_after_link_R4: assert property (@(posedge clk) disable iff (!rst_n)
      warn_shutdown |-> sus_link_bad);

   assert_pwr_hw_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(coil_pwr_off) |-> $past(hw_mode));

   assert_clear_drops_R10: assert property (@(posedge clk) disable iff (!rst_n)
      clr_ok |=> (!sus_link_bad && !sei_dac_kill && !coil_pwr_off));

endmodule

// File: tb/cascade_wdog_test.sv
module cascade_wdog_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       over_level = 1'b0;
   logic       clear_req = 1'b0;
   logic       hw_mode = 1'b0;
   logic       sus_link_bad, sei_link_bad, warn_shutdown;
   logic       sei_dac_kill, sus_dac_kill, coil_pwr_off;
   logic [3:0] sus_state, sei_state;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   cascade_wdog uut (
      .clk           (clk),
      .rst_n         (rst_n),
      .tick          (tick),
      .over_level    (over_level),
      .clear_req     (clear_req),
      .hw_mode       (hw_mode),
      .sus_link_bad  (sus_link_bad),
      .sei_link_bad  (sei_link_bad),
      .warn_shutdown (warn_shutdown),
      .sei_dac_kill  (sei_dac_kill),
      .sus_dac_kill  (sus_dac_kill),
      .coil_pwr_off  (coil_pwr_off),
      .sus_state     (sus_state),
      .sei_state     (sei_state)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk) tick = 1'b1;
         @(negedge clk) tick = 1'b0;
         idle(2);
      end
   endtask

   task automatic do_clear();
      @(negedge clk) clear_req = 1'b1;
      @(negedge clk) clear_req = 1'b0;
      idle(1);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      idle(3);
      rst_n = 1'b1;
      idle(1);
      chk("R1 outputs", {26'd0, sus_link_bad, sei_link_bad, warn_shutdown,
          sei_dac_kill, sus_dac_kill, coil_pwr_off}, 32'd0);
      chk("R1 R11 sus_state", {28'd0, sus_state}, 32'h1);
      chk("R1 R11 sei_state", {28'd0, sei_state}, 32'h1);
   endtask

   task automatic t_normal_chain();
      over_level = 1'b1;
      idle(2);
      chk("R2 R11 enters count1", {28'd0, sus_state}, 32'h2);
      idle(20);
      chk("R2 no tick no progress state", {28'd0, sus_state}, 32'h2);
      chk("R2 no tick no link", {31'd0, sus_link_bad}, 32'd0);
      ticks(4);
      chk("R2 link low at tick 4", {31'd0, sus_link_bad}, 32'd0);
      ticks(1);
      chk("R2 link bad at tick 5", {31'd0, sus_link_bad}, 32'd1);
      chk("R2 R11 sus count2", {28'd0, sus_state}, 32'h4);
      chk("R4 R11 sei count1", {28'd0, sei_state}, 32'h2);
      ticks(3);
      chk("R4 warn low at tick 8", {31'd0, warn_shutdown}, 32'd0);
      ticks(1);
      chk("R4 warn at tick 9", {31'd0, warn_shutdown}, 32'd1);
      chk("R4 sei link at tick 9", {31'd0, sei_link_bad}, 32'd1);
      chk("R4 R11 sei count2", {28'd0, sei_state}, 32'h4);
      chk("R5 no iso kill at tick 9", {31'd0, sei_dac_kill}, 32'd0);
      ticks(1);
      chk("R5 iso kill at tick 10", {31'd0, sei_dac_kill}, 32'd1);
      chk("R5 sus kill not yet", {31'd0, sus_dac_kill}, 32'd0);
      chk("R5 R11 sei killed", {28'd0, sei_state}, 32'h8);
      ticks(9);
      chk("R6 sus kill low at tick 19", {31'd0, sus_dac_kill}, 32'd0);
      ticks(1);
      chk("R6 sus kill at tick 20", {31'd0, sus_dac_kill}, 32'd1);
      chk("R6 R11 sus killed", {28'd0, sus_state}, 32'h8);
      ticks(5);
      chk("R8 no power removal in normal mode", {31'd0, coil_pwr_off}, 32'd0);
      do_clear();
      chk("R9 clear ignored while tripped", {30'd0, sus_dac_kill, sei_dac_kill}, 32'h3);
      over_level = 1'b0;
      ticks(3);
      chk("R9 outputs latched after flag drop",
          {28'd0, sus_link_bad, warn_shutdown, sei_dac_kill, sus_dac_kill}, 32'hF);
      do_clear();
      chk("R10 outputs released",
          {27'd0, sus_link_bad, sei_link_bad, warn_shutdown, sei_dac_kill, sus_dac_kill},
          32'd0);
      chk("R10 states idle", {24'd0, sus_state, sei_state}, 32'h11);
   endtask

   task automatic t_abort();
      over_level = 1'b1;
      idle(1);
      ticks(4);
      over_level = 1'b0;
      idle(2);
      chk("R3 abort to idle", {28'd0, sus_state}, 32'h1);
      ticks(5);
      chk("R3 no link after abort", {31'd0, sus_link_bad}, 32'd0);
      over_level = 1'b1;
      idle(1);
      ticks(4);
      chk("R3 count restarted", {31'd0, sus_link_bad}, 32'd0);
      ticks(1);
      chk("R3 full interval after restart", {31'd0, sus_link_bad}, 32'd1);
      over_level = 1'b0;
      do_clear();
   endtask

   task automatic t_hw_chain();
      hw_mode = 1'b1;
      over_level = 1'b1;
      idle(1);
      ticks(9);
      chk("R7 link low at hw tick 9", {31'd0, sus_link_bad}, 32'd0);
      ticks(1);
      chk("R7 link bad at hw tick 10", {31'd0, sus_link_bad}, 32'd1);
      ticks(9);
      chk("R7 iso kill low at hw tick 19", {31'd0, sei_dac_kill}, 32'd0);
      chk("R8 power on at hw tick 19", {31'd0, coil_pwr_off}, 32'd0);
      ticks(1);
      chk("R7 iso kill at hw tick 20", {31'd0, sei_dac_kill}, 32'd1);
      chk("R8 power removed at hw tick 20", {31'd0, coil_pwr_off}, 32'd1);
      ticks(19);
      chk("R7 sus kill low at hw tick 39", {31'd0, sus_dac_kill}, 32'd0);
      ticks(1);
      chk("R7 sus kill at hw tick 40", {31'd0, sus_dac_kill}, 32'd1);
      over_level = 1'b0;
      idle(1);
      chk("R9 power removal latched", {31'd0, coil_pwr_off}, 32'd1);
      do_clear();
      chk("R10 power restored", {31'd0, coil_pwr_off}, 32'd0);
      hw_mode = 1'b0;
   endtask

   task automatic t_pwr_break();
      hw_mode = 1'b1;
      over_level = 1'b1;
      idle(1);
      ticks(10);
      over_level = 1'b0;
      idle(2);
      over_level = 1'b1;
      idle(1);
      ticks(15);
      chk("R8 broken trip restarts power count", {31'd0, coil_pwr_off}, 32'd0);
      ticks(5);
      chk("R8 power removed after unbroken run", {31'd0, coil_pwr_off}, 32'd1);
      over_level = 1'b0;
      do_clear();
      hw_mode = 1'b0;
   endtask

   bit done = 1'b0;

   initial begin
      t_reset();
      t_normal_chain();
      t_abort();
      t_hw_chain();
      t_pwr_break();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run hung actual=running expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule